// File: doc/BRIEF.md
# XNOR Feedback Shift Sequencer

This block is a four-bit shift register that produces a fixed sequence with no external data input. On each enabled clock the contents move one place from the most significant bit toward the least significant bit. The new most significant bit is the XNOR of the current top and bottom bits. Because the feedback inverts, the all-zero state lies on a cycle of fifteen states. After reset the register is all zeros, and it comes back to all zeros after exactly fifteen enabled steps.

The all-ones state is the only pattern outside the cycle. Under this feedback it maps onto itself, so the block flags it and clears the register on the next clock. A load port writes an arbitrary seed, which lets a caller start anywhere on the cycle. A one-cycle wrap pulse marks each completed lap back to zero. Typical uses are as a cheap pseudo-random step source or a divide-by-fifteen phase counter.

Top module: `xnor_shift_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `state` to 0000 and `wrap` to 0. Reset overrides `load` and `en`.
- R2: On an enabled step (`en` high, `load` low, state not 1111), the new `state[2:0]` equals the old `state[3:1]`.
- R3: On an enabled step, the new `state[3]` equals XNOR of the old `state[3]` and `state[0]`.
- R4: Starting at 0000, the enabled steps give 1000, 0100, 1010, 0101, 0010, 1001, 1100, 0110, 1011, 1101, 1110, 0111, 0011, 0001, and then 0000 again on the fifteenth step. Values are written as `state[3:0]`.
- R5: With `en` low, `load` low and state not 1111, `state` holds its value across a clock.
- R6: With `load` high and `rst` low, `state` takes `seed` at the next clock, whatever `en` is.
- R7: `lockup` is high exactly while `state` is 1111. From 1111, the next clock sets `state` to 0000 whatever `en` is, unless reset or load applies.
- R8: `wrap` is high for exactly one cycle after an enabled step from 0001 to 0000. It stays low when 0000 is entered by reset, by load, or by lock-up recovery.
- R9: From any seed other than 1111, enabled stepping never reaches 1111, and the state returns to the seed after fifteen steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the sequence by one step |
| load | input | 1 | Write `seed` into the register |
| seed | input | 4 | Value written when `load` is high |
| state | output | 4 | Parallel register contents, bit 3 is the entry end |
| wrap | output | 1 | One-cycle pulse after a lap back to 0000 |
| lockup | output | 1 | High while the register holds 1111 |

## Verification
The block has no parameters. The bench builds it once at its fixed four-bit width, which puts all sixteen register values within reach of a directed test. Every one of the fifteen legal seeds is loaded and stepped through a full lap against an independent next-state model. The single illegal value is forced through the load port so that the flag and the recovery can be observed at the outputs.

// File: rtl/xnor_shift_seq.sv
module xnor_shift_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic [3:0] seed,
  output logic [3:0] state,
  output logic       wrap,
  output logic       lockup
);

  logic [3:0] q;
  logic       wrap_q;
  logic       fb;
  logic       stuck;

  assign stuck = &q;
  assign fb    = ~(q[3] ^ q[0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 4'b0000;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load) begin
        q <= seed;
      end else if (stuck) begin
        q <= 4'b0000;
      end else if (en) begin
        q      <= {fb, q[3:1]};
        wrap_q <= (q == 4'b0001);
      end
    end
  end

  assign state  = q;
  assign wrap   = wrap_q;
  assign lockup = stuck;

endmodule

// File: rtl/xnor_shift_seq_chk.sv
module xnor_shift_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic       load,
  input logic [3:0] seed,
  input logic [3:0] state,
  input logic       wrap,
  input logic       lockup
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (state == 4'b0000) && !wrap); // R1

  AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state != 4'b1111) |=> state[2:0] == $past(state[3:1])); // R2

  AST_FEEDBACK_BIT: assert property (@(posedge clk) disable iff (rst)
    (en && !load && state != 4'b1111) |=> state[3] == ~($past(state[3]) ^ $past(state[0]))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en && !load && state != 4'b1111) |=> $stable(state)); // R5

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed)); // R6

  AST_LOCKUP_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (state == 4'b1111 && !load) |=> state == 4'b0000); // R7

  AST_WRAP_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (state == 4'b0000) && ($past(state) == 4'b0001) && $past(en) && !$past(load)); // R8

  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap); // R8

  AST_NEVER_ENTER_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!load && state != 4'b1111) |=> state != 4'b1111); // R9

endmodule

bind xnor_shift_seq xnor_shift_seq_chk chk_i (.*);

// File: tb/xnor_shift_seq_tb_top.sv
`timescale 1ns/1ps
module xnor_shift_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       load = 1'b0;
  logic [3:0] seed = 4'b0000;
  logic [3:0] state;
  logic       wrap;
  logic       lockup;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  xnor_shift_seq dut_i (
    .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
    .state(state), .wrap(wrap), .lockup(lockup)
  );

  function automatic logic [3:0] model_next(input logic [3:0] s);
    if (s == 4'b1111) return 4'b0000;
    return {~(s[3] ^ s[0]), s[3:1]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; load = 1'b1; seed = 4'b1010; en = 1'b1;
    tick(); tick();
    check(state == 4'b0000, "R1 state", state, 0);
    check(!wrap, "R1 wrap", wrap, 0);
    check(!lockup, "R7 lockup idle", lockup, 0);
    rst = 1'b0; load = 1'b0; en = 1'b0;
  endtask

  task automatic t_sequence();
    logic [3:0] exp_list [15] = '{4'h8, 4'h4, 4'hA, 4'h5, 4'h2, 4'h9, 4'hC,
                                  4'h6, 4'hB, 4'hD, 4'hE, 4'h7, 4'h3, 4'h1, 4'h0};
    logic [3:0] prev;
    en = 1'b1;
    for (int i = 0; i < 15; i++) begin
      prev = state;
      tick();
      check(state == exp_list[i], "R4 listed order", state, exp_list[i]);
      check(state[2:0] == prev[3:1], "R2 shift", state[2:0], prev[3:1]);
      check(state[3] == ~(prev[3] ^ prev[0]), "R3 feedback", state[3], ~(prev[3] ^ prev[0]));
      check(wrap == (i == 14), "R8 wrap at lap end", wrap, i == 14);
    end
    tick();
    check(!wrap, "R8 wrap one cycle", wrap, 0);
    check(state == 4'h8, "R4 continues", state, 8);
    en = 1'b0;
  endtask

  task automatic t_hold();
    logic [3:0] keep;
    en = 1'b0;
    keep = state;
    for (int i = 0; i < 3; i++) begin
      tick();
      check(state == keep, "R5 hold", state, keep);
    end
  endtask

  task automatic t_load_priority();
    en = 1'b1; load = 1'b1; seed = 4'b0101;
    tick();
    check(state == 4'b0101, "R6 load over enable", state, 5);
    en = 1'b0; seed = 4'b1100;
    tick();
    check(state == 4'b1100, "R6 load with enable low", state, 4'hC);
    rst = 1'b1; seed = 4'b0110;
    tick();
    check(state == 4'b0000, "R1 reset over load", state, 0);
    rst = 1'b0; load = 1'b0;
  endtask

  task automatic t_lockup();
    load = 1'b1; seed = 4'b1111;
    tick();
    load = 1'b0; en = 1'b0;
    check(state == 4'b1111, "R7 forced 1111", state, 4'hF);
    check(lockup, "R7 lockup flag", lockup, 1);
    tick();
    check(state == 4'b0000, "R7 recovery without enable", state, 0);
    check(!lockup, "R7 flag clears", lockup, 0);
    check(!wrap, "R8 no wrap on recovery", wrap, 0);
  endtask

  task automatic t_wrap_exclusions();
    load = 1'b1; seed = 4'b0001;
    tick();
    seed = 4'b0000;
    tick();
    load = 1'b0;
    check(state == 4'b0000, "R6 load zero", state, 0);
    check(!wrap, "R8 no wrap on load", wrap, 0);
    load = 1'b1; seed = 4'b0001;
    tick();
    load = 1'b0; rst = 1'b1;
    tick();
    rst = 1'b0;
    check(!wrap, "R8 no wrap on reset", wrap, 0);
    load = 1'b1; seed = 4'b0001;
    tick();
    load = 1'b0; en = 1'b1;
    tick();
    check(wrap && state == 4'b0000, "R8 wrap after 0001 step", {wrap, state}, 5'h10);
    en = 1'b0;
    tick();
    check(!wrap, "R8 wrap drops while idle", wrap, 0);
  endtask

  task automatic t_all_seeds();
    logic [3:0] exp_s;
    bit saw_lock;
    for (int s = 0; s < 15; s++) begin
      load = 1'b1; seed = 4'(s);
      tick();
      load = 1'b0; en = 1'b1;
      exp_s = 4'(s);
      saw_lock = 1'b0;
      for (int k = 0; k < 15; k++) begin
        tick();
        exp_s = model_next(exp_s);
        if (state == 4'b1111 || lockup) saw_lock = 1'b1;
        check(state == exp_s, "R9 model step", state, exp_s);
      end
      check(!saw_lock, "R9 no lock-up reached", saw_lock, 0);
      check(state == 4'(s), "R9 lap returns to seed", state, s);
      en = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_hold();
    t_load_priority();
    t_lockup();
    t_wrap_exclusions();
    t_all_seeds();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule